// File: doc/BRIEF.md
# Fall-Through Word Stack

This block is the storage core of a small hardware queue. It keeps up to 62 words of 4 bits in a chain of slots. Each slot has its own occupancy flag and a data register. A word written into the top slot moves down by one slot on every clock edge while the slot beneath it is free. It stops only when it meets an occupied slot or reaches the bottom. No addresses or pointers are used: a word's position in the chain is its place in the queue.

The top edge faces an input register. A `top_empty` output tells that register when it may write, and a push is accepted only while the top slot is empty. The bottom edge faces an output register. `bottom_valid` marks a word waiting in the last slot, and `out_take` removes it. In the default flow mode, a slot also moves down when the slot beneath it is being vacated on the same edge, so a full chain drains one word per clock. Reset clears only the occupancy flags and leaves the data registers as they were.

Top module: `ftc_stack`

## Requirements
- R1: While reset is low, and on the first sample after its release, `top_empty` is 1 and `bottom_valid` is 0.
- R2: A push is accepted on a rising clock edge only when `in_push` is 1 and `top_empty` is 1. After an accepted push, `top_empty` reads 0 on the next cycle. A push presented while `top_empty` is 0 has no effect.
- R3: A single word pushed into an empty chain of 62 slots raises `bottom_valid` on the 62nd rising edge, counting the accepting edge as the first. After 61 edges, `bottom_valid` is still 0.
- R4: Words appear at `out_word` in the order they were accepted. No word is lost and none is delivered twice.
- R5: Exactly 62 words can be held. After 62 accepted pushes with no take, `top_empty` stays 0, and further pushes change nothing.
- R6: While `bottom_valid` is 1 and `out_take` is 0, `bottom_valid` stays 1 and `out_word` holds its value.
- R7: `out_take` while `bottom_valid` is 0 removes nothing and delivers nothing.
- R8: Reset clears the occupancy flags only. `out_word` keeps the value of the bottom data register across reset, and no word held before reset reappears afterwards.
- R9: In the default flow mode, a full chain with `out_take` held at 1 shows `bottom_valid` at 1 for 62 consecutive cycles, one word per cycle. On the cycle after that, `bottom_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low reset of the occupancy flags |
| in_push | input | 1 | Write request from the input register |
| in_word | input | WIDTH | Word to write into the top slot |
| top_empty | output | 1 | Top slot is free; a push would be accepted |
| out_take | input | 1 | Removes the bottom word when `bottom_valid` is 1 |
| bottom_valid | output | 1 | Bottom slot holds a word |
| out_word | output | WIDTH | Contents of the bottom data register |

## Verification
The bench measures the fall-through time of a lone word to the exact edge. A chain that skips or stalls a slot would raise `bottom_valid` early or late.

It fills the chain to capacity and then offers more pushes. A top slot that accepts writes while occupied would overwrite a word, and the scoreboard would see a stray or missing value.

It drains a full chain with `out_take` held high, so a flow rule that ignores a slot being vacated shows up as gaps in `bottom_valid`. It also holds `out_take` on an empty chain and resets while a word sits at the bottom. A design that pops phantoms, clears the data registers, or lets a pre-reset word resurface would show it at `out_word` or `bottom_valid`.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

   // How an occupied slot decides to move down.
   typedef enum logic [0:0] {
      FLOW_EMPTY_ONLY = 1'b0,   // move only into a slot already empty
      FLOW_RIPPLE     = 1'b1    // also move into a slot vacated on the same edge
   } flow_e;

   // Width of a counter that must hold the values 0..n.
   function automatic int level_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ftc_slot.sv
module ftc_slot #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             unload,
   input  logic [WIDTH-1:0] din,
   output logic             occ,
   output logic [WIDTH-1:0] dout
);

   logic             occ_q;
   logic [WIDTH-1:0] data_q;

   // Occupancy is control state: cleared by reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q <= 1'b0;
      end else begin
         occ_q <= (occ_q & ~unload) | load;
      end
   end

   // Data is not reset; it is only written when a word arrives.
   always_ff @(posedge clk) begin
      if (load) begin
         data_q <= din;
      end
   end

   assign occ  = occ_q;
   assign dout = data_q;

endmodule

// File: rtl/ftc_flow.sv
module ftc_flow #(
   parameter int            DEPTH = 62,
   parameter ftc_pkg::flow_e FLOW = ftc_pkg::FLOW_RIPPLE
) (
   input  logic [DEPTH-1:0] occ,
   input  logic             take,
   output logic [DEPTH-1:0] move
);

   localparam int LAST = DEPTH - 1;

   generate
      if (FLOW == ftc_pkg::FLOW_RIPPLE) begin : g_ripple
         // Evaluated bottom-up: a slot may follow a neighbour that leaves now.
         always_comb begin
            move       = '0;
            move[LAST] = occ[LAST] & take;
            for (int i = LAST - 1; i >= 0; i--) begin
               move[i] = occ[i] & (~occ[i+1] | move[i+1]);
            end
         end
      end else begin : g_empty_only
         // Each decision looks only at the neighbour's present flag.
         always_comb begin
            move       = '0;
            move[LAST] = occ[LAST] & take;
            for (int i = 0; i < LAST; i++) begin
               move[i] = occ[i] & ~occ[i+1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ftc_stack.sv
module ftc_stack #(
   parameter int             DEPTH = 62,
   parameter int             WIDTH = 4,
   parameter ftc_pkg::flow_e FLOW  = ftc_pkg::FLOW_RIPPLE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_push,
   input  logic [WIDTH-1:0] in_word,
   output logic             top_empty,
   input  logic             out_take,
   output logic             bottom_valid,
   output logic [WIDTH-1:0] out_word
);

   localparam int LAST = DEPTH - 1;

   initial begin
      assert (DEPTH >= 2) else $error("ftc_stack: DEPTH must be at least 2");
      assert (WIDTH >= 1) else $error("ftc_stack: WIDTH must be at least 1");
   end

   logic [DEPTH-1:0] occ;
   logic [DEPTH-1:0] move;
   logic [DEPTH-1:0] load;
   logic [WIDTH-1:0] slot_q [DEPTH];
   logic             accept;

   // Top slot takes a word only while it is empty.
   assign accept = in_push & ~occ[0];

   ftc_flow #(.DEPTH(DEPTH), .FLOW(FLOW)) u_flow (
      .occ  (occ),
      .take (out_take),
      .move (move)
   );

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         logic [WIDTH-1:0] din;
         if (s == 0) begin : g_head
            assign load[s] = accept;
            assign din     = in_word;
         end else begin : g_body
            assign load[s] = move[s-1];
            assign din     = slot_q[s-1];
         end
         ftc_slot #(.WIDTH(WIDTH)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load[s]),
            .unload (move[s]),
            .din    (din),
            .occ    (occ[s]),
            .dout   (slot_q[s])
         );
      end
   endgenerate

   assign top_empty    = ~occ[0];
   assign bottom_valid = occ[LAST];
   assign out_word     = slot_q[LAST];

endmodule

// File: rtl/ftc_stack_chk.sv
module ftc_stack_chk #(
   parameter int DEPTH = 62,
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_push,
   input logic [WIDTH-1:0] in_word,
   input logic             top_empty,
   input logic             out_take,
   input logic             bottom_valid,
   input logic [WIDTH-1:0] out_word
);

   localparam int LW = ftc_pkg::level_bits(DEPTH + 1);

   // Words held, tracked from the handshakes alone.
   logic [LW-1:0] level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else begin
         level <= level + LW'(in_push & top_empty) - LW'(out_take & bottom_valid);
      end
   end

   AST_TOP_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      in_push && top_empty |=> !top_empty);                                    // R2
   AST_BOTTOM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      bottom_valid && !out_take |=> bottom_valid && $stable(out_word));         // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));                                                     // R5
   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      level == LW'(DEPTH) |-> !top_empty);                                      // R5
   AST_VALID_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      bottom_valid |-> level != '0);                                            // R4

endmodule

bind ftc_stack ftc_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_push      (in_push),
   .in_word      (in_word),
   .top_empty    (top_empty),
   .out_take     (out_take),
   .bottom_valid (bottom_valid),
   .out_word     (out_word)
);

// File: tb/tb_ftc_stack.sv
module tb_ftc_stack;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 62;
   localparam int WIDTH      = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_push = 1'b0;
   logic [WIDTH-1:0] in_word = '0;
   logic             top_empty;
   logic             out_take = 1'b0;
   logic             bottom_valid;
   logic [WIDTH-1:0] out_word;

   int               checks = 0;
   int               errors = 0;
   logic             take_en = 1'b0;
   logic             throttle = 1'b0;
   int               cyc = 0;
   logic [WIDTH-1:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ftc_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
      .clk(clk), .rst_n(rst_n), .in_push(in_push), .in_word(in_word),
      .top_empty(top_empty), .out_take(out_take),
      .bottom_valid(bottom_valid), .out_word(out_word)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: waits for a free top slot, then offers one word.
   task automatic push_word(input logic [WIDTH-1:0] w);
      @(negedge clk);
      while (!top_empty) @(negedge clk);
      in_word = w;
      in_push = 1'b1;
      exp_q.push_back(w);
      @(negedge clk);
      in_push = 1'b0;
   endtask

   // Monitor: samples and drives take on the falling edge.
   always @(negedge clk) begin
      cyc++;
      if (take_en && (!throttle || (cyc % 3 == 0))) begin
         if (bottom_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4/R7 unexpected word", int'(out_word), -1);
            end else begin
               logic [WIDTH-1:0] e;
               e = exp_q.pop_front();
               check(out_word == e, "R4 order", int'(out_word), int'(e));
            end
         end
         out_take = 1'b1;
      end else begin
         out_take = 1'b0;
      end
   end

   initial begin
      repeat (1000000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(top_empty == 1'b1, "R1 top_empty in reset", top_empty, 1);
      check(bottom_valid == 1'b0, "R1 bottom_valid in reset", bottom_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(top_empty == 1'b1, "R1 top_empty after reset", top_empty, 1);
      check(bottom_valid == 1'b0, "R1 bottom_valid after reset", bottom_valid, 0);

      // R3 / R2: single-word fall-through time
      @(negedge clk);
      in_word = 4'h9;
      in_push = 1'b1;
      exp_q.push_back(4'h9);
      @(negedge clk);                 // accepting edge seen: 1 edge
      in_push = 1'b0;
      check(top_empty == 1'b0, "R2 top taken after push", top_empty, 0);
      repeat (60) @(negedge clk);     // 61 edges
      check(bottom_valid == 1'b0, "R3 not yet at bottom", bottom_valid, 0);
      @(negedge clk);                 // 62 edges
      check(bottom_valid == 1'b1, "R3 at bottom on 62nd edge", bottom_valid, 1);
      check(out_word == 4'h9, "R3 word value", out_word, 9);
      repeat (5) @(negedge clk);
      check(bottom_valid == 1'b1 && out_word == 4'h9, "R6 held while not taken",
            out_word, 9);

      // R8: reset keeps data, drops flags
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_q.delete();
      @(negedge clk);
      check(bottom_valid == 1'b0, "R8 flag cleared", bottom_valid, 0);
      check(top_empty == 1'b1, "R8 top free", top_empty, 1);
      check(out_word == 4'h9, "R8 data kept", out_word, 9);
      repeat (70) @(negedge clk);
      check(bottom_valid == 1'b0, "R8 no resurfacing word", bottom_valid, 0);

      // R7: take on an empty chain, then one word still arrives intact
      @(posedge clk);
      take_en = 1'b1;
      repeat (10) @(negedge clk);
      check(bottom_valid == 1'b0, "R7 empty take", bottom_valid, 0);
      push_word(4'h5);
      repeat (70) @(negedge clk);
      check(exp_q.size() == 0, "R7 word delivered once", exp_q.size(), 0);

      // R4: streaming with a throttled consumer
      throttle = 1'b1;
      for (int i = 0; i < 40; i++) push_word(WIDTH'((i * 7 + 3) & 15));
      repeat (250) @(negedge clk);
      check(exp_q.size() == 0, "R4 stream drained", exp_q.size(), 0);
      throttle = 1'b0;

      // R5: fill to capacity with no take
      @(posedge clk);
      take_en = 1'b0;
      for (int i = 0; i < DEPTH; i++) push_word(WIDTH'(i & 15));
      repeat (80) @(negedge clk);
      check(top_empty == 1'b0, "R5 full blocks top", top_empty, 0);
      check(bottom_valid == 1'b1, "R5 bottom filled", bottom_valid, 1);
      in_word = 4'hF;
      in_push = 1'b1;
      repeat (3) @(negedge clk);
      in_push = 1'b0;
      check(exp_q.size() == DEPTH, "R5 held count", exp_q.size(), DEPTH);

      // R9: full chain drains one word per clock
      @(posedge clk);
      take_en = 1'b1;
      n = 0;
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         if (bottom_valid) n++;
      end
      check(n == DEPTH, "R9 back-to-back valid", n, DEPTH);
      @(negedge clk);
      check(bottom_valid == 1'b0, "R9 empty after drain", bottom_valid, 0);
      check(exp_q.size() == 0, "R5 exactly 62 delivered", exp_q.size(), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule